// File: doc/BRIEF.md
# SPI Serial Clock Rate Generator

This block produces the serial clock for an SPI master from the system clock. An 8-bit divisor code D sets the rate. Each half of an SCK period lasts exactly D system clocks, so SCK runs at the system clock divided by 2·D. Codes 2 to 255 are active and give 254 usable rates. Codes 0 and 1 switch the generator off. Next to SCK the block drives two one-cycle strobes for the shift logic. One marks the cycle in which SCK leaves its idle level and the other marks the cycle in which it comes back.

Software programs the block through a small write port that reaches two registers. The divisor register resets to 4, which gives divide-by-8. The 16-bit control register resets to 0x0404. It carries the enable bit and two delay fields. This block only stores the delay fields and shows them on an output; it does not apply them. A transfer request is a valid/ready handshake. The requester raises `start_valid` and must hold it until `start_ready` is high at a clock edge, and the transfer is accepted at that edge. `start_ready` stays low while a transfer runs, while the block is disabled, while the divisor is invalid, and in any cycle that carries a write which would stop a transfer. A request that is not accepted has no effect. A transfer is a fixed run of `XFER_BITS` SCK periods.

Top module: `sck_rate_gen`

## Requirements
- R1: After reset the divisor register reads 4, the control register reads 0x0404, `running` and `pin_own` are 0, and `sck` equals `cpol`.
- R2: A write with `wr_sel`=0 loads `wr_data[7:0]` into the divisor register. A write with `wr_sel`=1 loads all 16 bits into the control register, whose fields are enable at bit 15, clock delay at bits 14:8 and post-transfer delay at bits 7:0. Both registers read back unchanged.
- R3: `pin_own` follows the enable bit (bit 15). `start_ready` is high only when enable is 1, the divisor is at least 2, no transfer runs, and the same cycle carries neither a control write nor a divisor write of 0 or 1.
- R4: A transfer is accepted at a clock edge where `start_valid` and `start_ready` are both high. `running` is high from the next cycle. It falls in the cycle of the last of 2·`XFER_BITS` SCK edges.
- R5: With divisor D, the first SCK edge comes D cycles after acceptance and each later edge comes D cycles after the one before it. D=17 gives a period of 34 cycles and D=255 gives 510.
- R6: The idle SCK level equals `cpol`. Whenever `running` is 0, `sck` equals `cpol`.
- R7: `lead_stb` is high for one cycle, in the cycle where SCK first shows the level away from idle. `trail_stb` is high for one cycle, in the cycle where SCK shows idle again after an edge. The two are never high together.
- R8: With a divisor of 0 or 1 no transfer is accepted and SCK stays idle. Writing 0 or 1 to the divisor while a transfer runs ends it at that edge.
- R9: A divisor write made during a transfer takes effect at the next half-period reload. The half-period already counting keeps its old length.
- R10: Any control write during a transfer drops `running` at that edge and returns SCK to idle, and no strobe comes from the abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the divisor register, 1 selects the control register |
| wr_data | input | 16 | Write data |
| cpol | input | 1 | Clock polarity, which is the idle SCK level |
| start_valid | input | 1 | Transfer request |
| start_ready | output | 1 | The block can accept a transfer this cycle |
| sck | output | 1 | Serial clock |
| lead_stb | output | 1 | SCK left idle this cycle |
| trail_stb | output | 1 | SCK returned to idle this cycle |
| running | output | 1 | A transfer is in progress |
| pin_own | output | 1 | The block owns the serial pins (enable bit) |
| div_val | output | 8 | Divisor register contents |
| ctrl_val | output | 16 | Control register contents |

## Verification
Two events can fall on the same system clock edge. A register write can land while the half-period counter expires or reloads, and an abort can land where a strobe is due. The bench provokes the first case by rewriting the divisor in the middle of a half-period. It then checks that the scoreboard's edge times use the old length for the current half and the new length from the following one. It provokes the second case by writing the control register or an invalid divisor just before a trailing edge is due. It checks that `running` falls, SCK is at idle, and no stray strobe reaches the monitor.

// File: rtl/sck_pkg.sv
package sck_pkg;
  typedef struct packed {
    logic       en;
    logic [6:0] clk_dly;
    logic [7:0] post_dly;
  } ctrl_t;

  localparam logic [15:0] CTRL_RESET = 16'h0404;
  localparam int          MIN_DIV    = 2;
endpackage

// File: rtl/sck_regs.sv
module sck_regs
  import sck_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [15:0]      wr_data,
  output logic [DIV_W-1:0] div_q,
  output ctrl_t            ctrl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= DIV_W'(DIV_RESET);
      ctrl_q <= ctrl_t'(CTRL_RESET);
    end else if (wr_en) begin
      if (wr_sel) ctrl_q <= ctrl_t'(wr_data);
      else        div_q  <= wr_data[DIV_W-1:0];
    end
  end

  // R2
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(div_q));
endmodule

// File: rtl/sck_halfcnt.sv
module sck_halfcnt #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [DIV_W-1:0] load_val,
  output logic             expire
);
  logic [DIV_W-1:0] cnt;

  assign expire = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (run && cnt != '0)  cnt <= cnt - 1'b1;
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/sck_phase.sv
module sck_phase #(
  parameter int XFER_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic abort,
  input  logic expire,
  output logic running,
  output logic phase,
  output logic lead_stb,
  output logic trail_stb
);
  localparam int EDGES = 2 * XFER_BITS;
  localparam int EW    = $clog2(EDGES + 1);

  logic [EW-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running   <= 1'b0;
      phase     <= 1'b0;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
      left      <= '0;
    end else begin
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
      if (abort) begin
        running <= 1'b0;
        phase   <= 1'b0;
      end else if (accept) begin
        running <= 1'b1;
        phase   <= 1'b0;
        left    <= EW'(EDGES);
      end else if (expire) begin
        phase     <= ~phase;
        lead_stb  <= ~phase;
        trail_stb <= phase;
        left      <= left - 1'b1;
        if (left == EW'(1)) running <= 1'b0;
      end
    end
  end

  // R6
  idle_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !phase);
  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_stb && trail_stb));
  // R7
  lead_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb |-> (phase && $past(!phase)));
  // R4
  accept_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !abort) |=> running);
endmodule

// File: rtl/sck_rate_gen.sv
module sck_rate_gen
  import sck_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 4,
  parameter int XFER_BITS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [15:0] wr_data,
  input  logic        cpol,
  input  logic        start_valid,
  output logic        start_ready,
  output logic        sck,
  output logic        lead_stb,
  output logic        trail_stb,
  output logic        running,
  output logic        pin_own,
  output logic [7:0]  div_val,
  output logic [15:0] ctrl_val
);
  logic [DIV_W-1:0] div_q;
  ctrl_t            ctrl_q;
  logic             phase, expire, accept, abort;
  logic             valid_div, ctrl_wr, bad_div_wr;

  sck_regs #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .div_q(div_q), .ctrl_q(ctrl_q)
  );

  assign valid_div  = div_q >= DIV_W'(MIN_DIV);
  assign ctrl_wr    = wr_en && wr_sel;
  assign bad_div_wr = wr_en && !wr_sel && (wr_data[DIV_W-1:0] < DIV_W'(MIN_DIV));
  assign abort      = running && (ctrl_wr || bad_div_wr);
  assign start_ready = ctrl_q.en && valid_div && !running && !ctrl_wr && !bad_div_wr;
  assign accept     = start_valid && start_ready;

  sck_halfcnt #(.DIV_W(DIV_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(running),
    .load(accept || expire), .load_val(div_q - 1'b1), .expire(expire)
  );

  sck_phase #(.XFER_BITS(XFER_BITS)) u_phase (
    .clk(clk), .rst_n(rst_n), .accept(accept), .abort(abort),
    .expire(expire), .running(running), .phase(phase),
    .lead_stb(lead_stb), .trail_stb(trail_stb)
  );

  assign sck      = cpol ^ phase;
  assign pin_own  = ctrl_q.en;
  assign div_val  = 8'(div_q);
  assign ctrl_val = ctrl_q;

  // R8
  bad_div_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_div |-> !running);
  // R3
  run_owns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> pin_own);
  // R10
  ctrl_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && ctrl_wr) |=> (!running && !lead_stb && !trail_stb));
endmodule

// File: tb/test_sck_rate_gen.sv
module test_sck_rate_gen;
  localparam int B = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0, cpol = 1'b0, start_valid = 1'b0;
  logic [15:0] wr_data = '0;
  logic start_ready, sck, lead_stb, trail_stb, running, pin_own;
  logic [7:0] div_val;
  logic [15:0] ctrl_val;

  sck_rate_gen #(.XFER_BITS(B)) i_sck_rate_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cpol(cpol), .start_valid(start_valid), .start_ready(start_ready),
    .sck(sck), .lead_stb(lead_stb), .trail_stb(trail_stb), .running(running),
    .pin_own(pin_own), .div_val(div_val), .ctrl_val(ctrl_val)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int t; bit lead; } ev_t;
  ev_t q[$];
  ev_t e_m;
  int tests = 0, fails = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (lead_stb && trail_stb) chk(0, "R7", "both strobes", 1, 0);
      if (lead_stb || trail_stb) begin
        if (q.size() == 0) chk(0, "R7", "unexpected strobe at cycle", cyc, -1);
        else begin
          e_m = q.pop_front();
          chk(cyc == e_m.t, "R5", "edge cycle", cyc, e_m.t);
          chk(lead_stb == e_m.lead, "R7", "strobe kind", lead_stb, e_m.lead);
          chk(sck == (cpol ^ lead_stb), "R6", "sck level at edge", sck, cpol ^ lead_stb);
        end
      end
    end
  end

  task automatic wr(bit sel, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic start_xfer(output int a);
    @(negedge clk);
    chk(start_ready, "R3", "start_ready before start", start_ready, 1);
    start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    a = cyc;
    chk(running, "R4", "running after accept", running, 1);
    chk(!start_ready, "R3", "ready low while running", start_ready, 0);
  endtask

  task automatic wait_done(int a, int exp_end, bit p);
    while (running) @(negedge clk);
    chk(cyc == exp_end, "R4", "transfer end cycle", cyc - a, exp_end - a);
    @(negedge clk);
    chk(q.size() == 0, "R5", "missing edges", q.size(), 0);
    chk(sck == p, "R6", "sck idle after transfer", sck, p);
  endtask

  task automatic run_xfer(bit do_wr, int d, bit p);
    int a;
    cpol = p;
    if (do_wr) wr(1'b0, 16'(d));
    start_xfer(a);
    for (int i = 1; i <= 2*B; i++) q.push_back('{a + i*d, (i % 2) == 1});
    wait_done(a, a + 2*B*d, p);
  endtask

  initial begin
    repeat (20 * 200000) @(posedge clk);
    chk(0, "R4", "watchdog expired", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(div_val == 8'd4, "R1", "divisor reset", div_val, 4);
    chk(ctrl_val == 16'h0404, "R1", "control reset", ctrl_val, 16'h0404);
    chk(!running && !pin_own, "R1", "running/pin_own reset", {running, pin_own}, 0);
    chk(sck == cpol, "R1", "sck idle at reset", sck, cpol);
    chk(!start_ready, "R3", "ready low while disabled", start_ready, 0);
    // R6 idle follows cpol
    cpol = 1'b1; #1;
    chk(sck == 1'b1, "R6", "idle sck follows cpol", sck, 1);
    cpol = 1'b0;

    // R2/R3 control fields and enable
    wr(1'b1, 16'h8A5C);
    chk(ctrl_val == 16'h8A5C, "R2", "control readback", ctrl_val, 16'h8A5C);
    chk(pin_own, "R3", "pin_own with enable", pin_own, 1);

    // R5 default divide by 8
    run_xfer(1'b0, 4, 1'b0);
    run_xfer(1'b1, 2, 1'b1);
    run_xfer(1'b1, 17, 1'b0);
    run_xfer(1'b1, 255, 1'b1);
    chk(div_val == 8'd255, "R2", "divisor readback", div_val, 255);

    // R9 divisor change mid-transfer
    cpol = 1'b0;
    wr(1'b0, 16'd3);
    start_xfer(a);
    q.push_back('{a + 3, 1'b1});
    q.push_back('{a + 6, 1'b0});
    for (int i = 3; i <= 2*B; i++) q.push_back('{a + 6 + 5*(i-2), (i % 2) == 1});
    while (cyc < a + 3) @(negedge clk);
    wr(1'b0, 16'd5);
    wait_done(a, a + 6 + 5*(2*B-2), 1'b0);

    // R10 control write aborts
    wr(1'b0, 16'd4);
    start_xfer(a);
    q.push_back('{a + 4, 1'b1});
    while (cyc < a + 5) @(negedge clk);
    wr(1'b1, 16'h8404);
    chk(!running, "R10", "running after control write", running, 1'b0);
    chk(sck == cpol, "R10", "sck idle after abort", sck, cpol);
    repeat (30) @(negedge clk);
    chk(q.size() == 0, "R10", "pending edges after abort", q.size(), 0);

    // R8 invalid divisor mid-transfer
    start_xfer(a);
    q.push_back('{a + 4, 1'b1});
    while (cyc < a + 5) @(negedge clk);
    wr(1'b0, 16'd1);
    chk(!running, "R8", "running after divisor 1", running, 0);
    chk(sck == cpol, "R8", "sck idle after divisor 1", sck, cpol);
    // R8 no start with divisor 1 or 0
    start_valid = 1'b1;
    repeat (10) @(negedge clk);
    chk(!running && !start_ready, "R8", "start with divisor 1", running, 0);
    start_valid = 1'b0;
    wr(1'b0, 16'd0);
    start_valid = 1'b1;
    repeat (10) @(negedge clk);
    chk(!running && sck == cpol, "R8", "start with divisor 0", running, 0);
    start_valid = 1'b0;

    // R3 enable cleared
    wr(1'b0, 16'd4);
    wr(1'b1, 16'h7F33);
    chk(!pin_own && !start_ready, "R3", "disabled ownership/ready", pin_own, 0);
    chk(ctrl_val == 16'h7F33, "R2", "control readback 2", ctrl_val, 16'h7F33);
    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R7", "leftover scoreboard items", q.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule